// File: doc/BRIEF.md
# Packed-Index Vector Table Lookup

This unit builds one destination vector of `VL` bits by looking up sixteen 32-bit entries held in a 512-bit table register. The indices are 4-bit fields packed into the source vector. The source vector is split into segments, and one segment is consumed per lookup.

The element width is set by a 2-bit size code. A 3-bit segment selector is reduced modulo the number of segments that fit at that width. Each destination element receives the low bits of the 32-bit entry it addresses, truncated to the element width. Every element is written on every lookup, because there is no predicate.

The table is loaded as a whole through a 512-bit write port. A lookup is requested with a one-cycle start pulse. The registered result appears one clock later together with a valid pulse. An illegal size code does not update the result; it raises an error pulse instead.

Top module: `nibble_table_lookup`

## Requirements
- R1: Reset clears the table, the result vector, the result-valid flag and the illegal-size flag to zero, so a lookup made straight after reset yields an all-zero result.
- R2: With size code 0, elements are 8 bits wide, there are VL/8 of them, and the segment is the selector modulo 2. Element e takes its index from 4-bit field number (segment·VL/8 + e) of the source vector, with fields counted from bit 0 upward. Element e occupies bits [8e+7:8e] of the result.
- R3: With size code 1, elements are 16 bits wide, there are VL/16 of them, and the segment is the selector modulo 4. The index field is number (segment·VL/16 + e).
- R4: With size code 2, elements are 32 bits wide, there are VL/32 of them, and the segment is the selector modulo 8. The index field is number (segment·VL/32 + e).
- R5: Table entry k occupies bits [32k+31:32k] of the table. Each element receives the low element-width bits of the entry its index selects.
- R6: Result-valid is high for exactly the one cycle that follows a start pulse with a legal size code, and is low at all other times.
- R7: A start pulse with size code 3 raises the illegal-size flag for the following cycle. It leaves the result vector unchanged and does not raise result-valid.
- R8: A table write takes effect at the next clock edge. A lookup started in the same cycle as a write uses the table contents from before that write.
- R9: Without a legal start pulse, the result vector keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Lookup request, one cycle |
| size_code | input | 2 | Element width code: 0=8, 1=16, 2=32 bits, 3=illegal |
| seg_sel | input | 3 | Segment selector, reduced modulo segment count |
| src_vec | input | VL | Source vector holding packed 4-bit indices |
| tbl_we | input | 1 | Table write enable |
| tbl_wdata | input | 512 | New table contents |
| res_vec | output | VL | Registered lookup result |
| res_valid | output | 1 | Result produced this cycle |
| size_err | output | 1 | Illegal size code seen on the last start |

## Verification
The bench builds the unit with VL = 256. At that width the three element sizes give 32, 16 and 8 elements, so the index fields of every segment at every width lie in distinct parts of the source vector. Because the size is moderate, random source vectors and random tables can be generated and compared in full against a model. Selector values from 0 to 7 wrap at all three segment counts, and table entries are filled with nonzero upper bits so that truncation to the element width can be observed.

// File: rtl/nibble_table_lookup.sv
module nibble_table_lookup #(
  parameter int VL = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    size_code,
  input  logic [2:0]    seg_sel,
  input  logic [VL-1:0] src_vec,
  input  logic          tbl_we,
  input  logic [511:0]  tbl_wdata,
  output logic [VL-1:0] res_vec,
  output logic          res_valid,
  output logic          size_err
);

  localparam int E8  = VL / 8;
  localparam int E16 = VL / 16;
  localparam int E32 = VL / 32;

  logic [511:0]  tbl_q;
  logic [VL-1:0] r8, r16, r32, next_res;
  logic [2:0]    s8, s16, s32;
  logic          legal;

  assign s8    = {2'b00, seg_sel[0]};
  assign s16   = {1'b0, seg_sel[1:0]};
  assign s32   = seg_sel;
  assign legal = (size_code != 2'd3);

  for (genvar e = 0; e < E8; e++) begin : g_b8
    logic [3:0] ix;
    assign ix = 4'(src_vec >> (4 * (int'(s8) * E8 + e)));
    assign r8[8*e +: 8] = 8'(tbl_q >> (32 * int'(ix)));
  end

  for (genvar e = 0; e < E16; e++) begin : g_b16
    logic [3:0] ix;
    assign ix = 4'(src_vec >> (4 * (int'(s16) * E16 + e)));
    assign r16[16*e +: 16] = 16'(tbl_q >> (32 * int'(ix)));
  end

  for (genvar e = 0; e < E32; e++) begin : g_b32
    logic [3:0] ix;
    assign ix = 4'(src_vec >> (4 * (int'(s32) * E32 + e)));
    assign r32[32*e +: 32] = 32'(tbl_q >> (32 * int'(ix)));
  end

  always_comb begin
    case (size_code)
      2'd0:    next_res = r8;
      2'd1:    next_res = r16;
      2'd2:    next_res = r32;
      default: next_res = res_vec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_q     <= '0;
      res_vec   <= '0;
      res_valid <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      if (tbl_we) tbl_q <= tbl_wdata;
      res_valid <= start && legal;
      size_err  <= start && !legal;
      if (start && legal) res_vec <= next_res;
    end
  end

  assert_valid_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && legal) |=> res_valid);
  assert_valid_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && legal) |=> !res_valid);
  assert_illegal_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legal) |=> (size_err && !res_valid && $stable(res_vec)));
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(res_vec));
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && size_err));

endmodule

// File: tb/tb_nibble_table_lookup.sv
module tb_nibble_table_lookup;
  localparam int VL = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    size_code = '0;
  logic [2:0]    seg_sel = '0;
  logic [VL-1:0] src_vec = '0;
  logic          tbl_we = 1'b0;
  logic [511:0]  tbl_wdata = '0;
  logic [VL-1:0] res_vec;
  logic          res_valid, size_err;

  int checks = 0;
  int fails = 0;
  logic [511:0]  mdl_tbl = '0;
  logic [VL-1:0] mdl_res = '0;

  always #4 clk = ~clk;

  nibble_table_lookup #(.VL(VL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .seg_sel(seg_sel), .src_vec(src_vec), .tbl_we(tbl_we),
    .tbl_wdata(tbl_wdata), .res_vec(res_vec), .res_valid(res_valid),
    .size_err(size_err));

  function automatic logic [VL-1:0] expect_vec(input logic [511:0] t,
      input logic [VL-1:0] s, input int sz, input int sel);
    int esz = 8 << sz;
    int ne  = VL / esz;
    int sg  = sel % (esz / 4);
    logic [VL-1:0] r = '0;
    for (int e = 0; e < ne; e++) begin
      int nib = int'(4'(s >> ((sg * ne + e) * 4)));
      logic [31:0] ent = 32'(t >> (nib * 32));
      logic [31:0] m = (esz == 32) ? 32'hFFFF_FFFF : ((32'd1 << esz) - 32'd1);
      r = r | (VL'(ent & m) << (e * esz));
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VL-1:0] rndvl();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [511:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
    mdl_tbl = d;
  endtask

  task automatic lookup(input string req, input int sz, input int sel,
      input logic [VL-1:0] s, input logic we, input logic [511:0] wd);
    @(negedge clk);
    start = 1'b1; size_code = 2'(sz); seg_sel = 3'(sel); src_vec = s;
    tbl_we = we; tbl_wdata = wd;
    @(negedge clk);
    start = 1'b0; tbl_we = 1'b0;
    if (sz != 3) mdl_res = expect_vec(mdl_tbl, s, sz, sel);
    check(req, res_vec, mdl_res);
    check(req, VL'(res_valid), VL'(sz != 3));
    check(req, VL'(size_err), VL'(sz == 3));
    if (we) mdl_tbl = wd;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0] tb;
    logic [VL-1:0] sv;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", res_vec, '0);
    check("R1", VL'(res_valid), '0);
    check("R1", VL'(size_err), '0);
    lookup("R1", 2, 3, rndvl(), 1'b0, '0);

    // R5: entries with busy upper bits
    for (int k = 0; k < 16; k++) tb[32*k +: 32] = {8'hA0 + 8'(k), 8'h5C, 8'h30 + 8'(k), 8'hE0 + 8'(k)};
    load_table(tb);
    for (int i = 0; i < VL/4; i++) sv[4*i +: 4] = 4'(i * 7 + 3);
    lookup("R2", 0, 0, sv, 1'b0, '0);
    lookup("R2", 0, 5, sv, 1'b0, '0);
    lookup("R3", 1, 6, sv, 1'b0, '0);
    lookup("R3", 1, 3, sv, 1'b0, '0);
    lookup("R4", 2, 7, sv, 1'b0, '0);
    lookup("R5", 2, 0, sv, 1'b0, '0);

    // R7 illegal size keeps result
    lookup("R7", 3, 2, rndvl(), 1'b0, '0);

    // R9 hold while idle
    mdl_res = res_vec;
    src_vec = rndvl(); size_code = 2'd0;
    repeat (3) @(negedge clk);
    check("R9", res_vec, mdl_res);
    check("R6", VL'(res_valid), '0);

    // R8 write and lookup together use old table
    lookup("R8", 0, 1, sv, 1'b1, rnd512());
    lookup("R8", 0, 1, sv, 1'b0, '0);

    for (int n = 0; n < 300; n++) begin
      int sz = int'($urandom % 4);
      logic w = ($urandom % 5) == 0;
      lookup((sz == 0) ? "R2" : (sz == 1) ? "R3" : (sz == 2) ? "R4" : "R7",
             sz, int'($urandom % 8), rndvl(), w, rnd512());
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule